// File: doc/BRIEF.md
# Keyed GPIO Bank Controller

This block is a memory-mapped general-purpose I/O controller for a parameterised number of 32-pin banks (one to eight). A plain 32-bit register bus reaches it. Each pin has its own configuration word, which holds the pin direction, which input edges raise an interrupt, and a four-bit debounce code. The debounce code is only stored. Output levels change through separate write-one-to-set and write-one-to-clear ports. Software can read back both the output latch and the synchronised input levels. Input edges feed a sticky interrupt status register, which has a mask and a separate unmask port. A single level `irq` line reports any pending unmasked event.

Every bank has a pin lock register, and all its bits come out of reset set. A pin whose lock bit is 1 ignores writes to its configuration word and to its output set and clear bits. The lock register can only be rewritten by the bus write that comes directly after the key word `0x00A5A501` is written to the key address `0x520`. Clearing a lock bit hands the pin to a user; setting it takes the pin back.

The bus accepts one request per cycle when `bus_valid` is high and never stalls. There is no ready signal, so there is no back-pressure. Read data is registered and appears with `bus_rvalid` high in the cycle after the request. Only word-aligned addresses decode. Bank `b` adds `4*b` to each bank register offset.

Top module: `gpio_keyed_bank`

## Requirements
- R1: After reset the output latch is 0, every lock bit is 1, every mask bit is 1, and every interrupt status bit is 0. Every configuration word reads `0x00000001`, which means input with no interrupt edge. `pin_oe` is all 0 and `irq` is 0.
- R2: Writing `0x00A5A501` to `0x520` arms exactly one following write, and only if that write goes to a lock register (`0x500 + 4*b`). That write replaces the bank's lock bits. A lock write without arming is ignored. Any other write in between, including a wrong key value, disarms. The lock register reads back at `0x500 + 4*b`.
- R3: While a pin's lock bit is 1, writes to that pin's configuration word and to its bit in the set and clear ports leave them unchanged.
- R4: Pin `n` has its configuration word at `0x100 + 4*n`. Bit 0 is the direction (1 = input, 0 = output), bits [4:3] are the edge code, and bits [8:5] are the debounce code. All other bits read 0. `pin_oe[n]` is the inverse of bit 0.
- R5: A write to `0x040 + 4*b` ORs the 1-bits into the output latch, and a write to `0x060 + 4*b` clears the latch bits written as 1. Reads of `0x000`, `0x040` and `0x060` (plus `4*b`) return the latch in either direction. `pin_out` equals the latch.
- R6: A read of `0x020 + 4*b` returns the pin inputs after a two-flop synchroniser. Every read returns its data with `bus_rvalid` in the following cycle.
- R7: On an input-direction pin, edge code 1 flags rising edges, 2 flags falling edges and 3 flags both, by setting that pin's bit at `0x080 + 4*b`. Edge code 0, or output direction, never sets it.
- R8: Writing 1 to an interrupt status bit clears it. Bits written as 0 keep their value.
- R9: Writing 1 to `0x0A0 + 4*b` masks a pin, and writing 1 to `0x0C0 + 4*b` unmasks it. Both addresses read the mask. `irq` is the OR over all pins of status AND NOT mask.
- R10: Reads of unmapped addresses, of banks at or beyond the bank count, of configuration words beyond the last pin, and of the key address return 0. Writes to those bank slots change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request strobe, accepted every cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| pin_in | input | NUM_BANKS*32 | Asynchronous pin inputs |
| pin_out | output | NUM_BANKS*32 | Output latch |
| pin_oe | output | NUM_BANKS*32 | Output enable, 1 for output-direction pins |
| irq | output | 1 | Pending unmasked interrupt |

## Verification
The bench builds the block with two banks. With that setting, a lock, mask or interrupt event can be seen in the second bank while the first bank stays untouched. Bank slots 2 to 7 and configuration addresses past pin 63 then fall into the out-of-range decode. Together they cover pin 32, the first pin across a bank boundary, and writes that land on no existing bank.

// File: rtl/gpio_keyed_pkg.sv
`timescale 1ns/1ps
package gpio_keyed_pkg;
  localparam int unsigned BANK_PINS = 32;

  localparam logic [11:0] CTRL_BASE = 12'h100;
  localparam logic [11:0] LOCK_BASE = 12'h500;
  localparam logic [11:0] KEY_ADDR  = 12'h520;
  localparam logic [31:0] KEY_WORD  = 32'h00A5_A501;

  // register group selected by address bits [7:5] in the bank region
  typedef enum logic [2:0] {
    GRP_OUT  = 3'd0,
    GRP_IN   = 3'd1,
    GRP_SET  = 3'd2,
    GRP_CLR  = 3'd3,
    GRP_IST  = 3'd4,
    GRP_MSK  = 3'd5,
    GRP_MCL  = 3'd6,
    GRP_NONE = 3'd7
  } grp_e;

  // bit 0 = rising, bit 1 = falling
  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_ANY  = 2'd3
  } trig_e;

  typedef struct packed {
    logic [3:0] dbnc;
    trig_e      trig;
    logic       dir_in;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{dbnc: 4'd0, trig: TRIG_OFF, dir_in: 1'b1};

  function automatic logic [31:0] cfg_to_word(input pin_cfg_t c);
    return {23'd0, c.dbnc, c.trig, 2'b00, c.dir_in};
  endfunction

  function automatic pin_cfg_t word_to_cfg(input logic [8:0] w);
    pin_cfg_t c;
    c.dir_in = w[0];
    c.trig   = trig_e'(w[4:3]);
    c.dbnc   = w[8:5];
    return c;
  endfunction
endpackage

// File: rtl/gpio_key_guard.sv
`timescale 1ns/1ps
module gpio_key_guard
  import gpio_keyed_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BW        = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_i,
  input  logic                           key_hit_i,
  input  logic                           lock_hit_i,
  input  logic [BW-1:0]                  bank_i,
  input  logic [31:0]                    wdata_i,
  output logic [NUM_BANKS*BANK_PINS-1:0] lock_o
);
  localparam int NPINS = NUM_BANKS * BANK_PINS;

  logic             armed_q;
  logic [NPINS-1:0] lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (wr_i) begin
      armed_q <= key_hit_i && (wdata_i == KEY_WORD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '1;
    end else if (lock_hit_i && armed_q) begin
      lock_q[int'(bank_i)*BANK_PINS +: BANK_PINS] <= wdata_i;
    end
  end

  assign lock_o = lock_q;

  AST_LOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock_q) |-> $past(armed_q && lock_hit_i)); // R2

  AST_KEY_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && lock_hit_i) |=> !armed_q); // R2
endmodule

// File: rtl/gpio_pin_cfg.sv
`timescale 1ns/1ps
module gpio_pin_cfg
  import gpio_keyed_pkg::*;
#(
  parameter int NPINS = 128,
  parameter int PW    = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [PW-1:0]      idx_i,
  input  pin_cfg_t           wcfg_i,
  input  logic [NPINS-1:0]   lock_i,
  output logic [NPINS-1:0]   dir_in_o,
  output logic [2*NPINS-1:0] trig_o,
  output logic [31:0]        rdata_o
);
  pin_cfg_t cfg_q [NPINS];

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[p] <= CFG_RESET;
      end else if (we_i && (int'(idx_i) == p) && !lock_i[p]) begin
        cfg_q[p] <= wcfg_i;
      end
    end

    assign dir_in_o[p]     = cfg_q[p].dir_in;
    assign trig_o[2*p +: 2] = cfg_q[p].trig;

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i[p] |=> $stable(cfg_q[p])); // R3
  end

  always_comb begin
    rdata_o = '0;
    if (int'(idx_i) < NPINS) rdata_o = cfg_to_word(cfg_q[idx_i]);
  end
endmodule

// File: rtl/gpio_edge_irq.sv
`timescale 1ns/1ps
module gpio_edge_irq
  import gpio_keyed_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BW        = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_BANKS*BANK_PINS-1:0]   pin_i,
  input  logic [NUM_BANKS*BANK_PINS-1:0]   dir_in_i,
  input  logic [2*NUM_BANKS*BANK_PINS-1:0] trig_i,
  input  logic                             ist_wr_i,
  input  logic                             msk_set_i,
  input  logic                             msk_clr_i,
  input  logic [BW-1:0]                    bank_i,
  input  logic [31:0]                      wdata_i,
  output logic [NUM_BANKS*BANK_PINS-1:0]   sync_o,
  output logic [NUM_BANKS*BANK_PINS-1:0]   ist_o,
  output logic [NUM_BANKS*BANK_PINS-1:0]   msk_o,
  output logic                             irq_o
);
  localparam int NPINS = NUM_BANKS * BANK_PINS;

  logic [NPINS-1:0] s1_q, s2_q, prev_q;
  logic [NPINS-1:0] ist_q, msk_q;
  logic [NPINS-1:0] hit, wvec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_edge
    assign hit[p] = dir_in_i[p] &
                    ((trig_i[2*p]   &  s2_q[p] & ~prev_q[p]) |
                     (trig_i[2*p+1] & ~s2_q[p] &  prev_q[p]));
  end

  always_comb begin
    wvec = '0;
    wvec[int'(bank_i)*BANK_PINS +: BANK_PINS] = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ist_q <= '0;
      msk_q <= '1;
    end else begin
      ist_q <= (ist_q & ~(ist_wr_i ? wvec : '0)) | hit;
      if (msk_set_i)      msk_q <= msk_q | wvec;
      else if (msk_clr_i) msk_q <= msk_q & ~wvec;
    end
  end

  assign sync_o = s2_q;
  assign ist_o  = ist_q;
  assign msk_o  = msk_q;
  assign irq_o  = |(ist_q & ~msk_q);

  AST_NO_STATUS_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((ist_q & ~$past(ist_q) & ~$past(dir_in_i)) == '0)); // R7

  AST_STATUS_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((ist_q & ~$past(ist_q) & ~$past(s2_q ^ prev_q)) == '0)); // R7
endmodule

// File: rtl/gpio_keyed_bank.sv
`timescale 1ns/1ps
module gpio_keyed_bank
  import gpio_keyed_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic [11:0]            bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   bus_rvalid,
  input  logic [NUM_BANKS*32-1:0] pin_in,
  output logic [NUM_BANKS*32-1:0] pin_out,
  output logic [NUM_BANKS*32-1:0] pin_oe,
  output logic                   irq
);
  localparam int NPINS = NUM_BANKS * BANK_PINS;
  localparam int BW    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int PW    = $clog2(NPINS);

  // address decode
  logic          wr_en, rd_en, aligned, bank_ok;
  logic [2:0]    a_bank;
  logic [BW-1:0] bsel;
  grp_e          grp;
  logic          in_bank, in_lock, in_key, in_ctrl;
  logic [PW-1:0] pin_idx;

  assign wr_en   = bus_valid & bus_write;
  assign rd_en   = bus_valid & ~bus_write;
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign a_bank  = bus_addr[4:2];
  assign bank_ok = (int'(a_bank) < NUM_BANKS);
  assign bsel    = a_bank[BW-1:0];
  assign grp     = grp_e'(bus_addr[7:5]);
  assign in_bank = aligned && (bus_addr[11:8] == 4'h0) && bank_ok;
  assign in_lock = aligned && (bus_addr[11:5] == LOCK_BASE[11:5]) && bank_ok;
  assign in_key  = (bus_addr == KEY_ADDR);
  assign in_ctrl = aligned && (bus_addr >= CTRL_BASE) &&
                   (int'(bus_addr) < int'(CTRL_BASE) + 4 * NPINS);
  assign pin_idx = PW'((bus_addr - CTRL_BASE) >> 2);

  logic set_we, clr_we, ist_we, msk_set, msk_clr;
  assign set_we  = wr_en && in_bank && (grp == GRP_SET);
  assign clr_we  = wr_en && in_bank && (grp == GRP_CLR);
  assign ist_we  = wr_en && in_bank && (grp == GRP_IST);
  assign msk_set = wr_en && in_bank && (grp == GRP_MSK);
  assign msk_clr = wr_en && in_bank && (grp == GRP_MCL);

  // sub-blocks
  logic [NPINS-1:0]   lock_q, dir_in, sync_v, ist_v, msk_v;
  logic [2*NPINS-1:0] trig_v;
  logic [31:0]        cfg_rdata;

  gpio_key_guard #(.NUM_BANKS(NUM_BANKS), .BW(BW)) u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_en),
    .key_hit_i  (wr_en && in_key),
    .lock_hit_i (wr_en && in_lock),
    .bank_i     (bsel),
    .wdata_i    (bus_wdata),
    .lock_o     (lock_q)
  );

  gpio_pin_cfg #(.NPINS(NPINS), .PW(PW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (wr_en && in_ctrl),
    .idx_i    (pin_idx),
    .wcfg_i   (word_to_cfg(bus_wdata[8:0])),
    .lock_i   (lock_q),
    .dir_in_o (dir_in),
    .trig_o   (trig_v),
    .rdata_o  (cfg_rdata)
  );

  gpio_edge_irq #(.NUM_BANKS(NUM_BANKS), .BW(BW)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin_in),
    .dir_in_i  (dir_in),
    .trig_i    (trig_v),
    .ist_wr_i  (ist_we),
    .msk_set_i (msk_set),
    .msk_clr_i (msk_clr),
    .bank_i    (bsel),
    .wdata_i   (bus_wdata),
    .sync_o    (sync_v),
    .ist_o     (ist_v),
    .msk_o     (msk_v),
    .irq_o     (irq)
  );

  // output latch
  logic [NPINS-1:0] out_q, set_v, clr_v;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    if (set_we) set_v[int'(bsel)*BANK_PINS +: BANK_PINS] = bus_wdata;
    if (clr_we) clr_v[int'(bsel)*BANK_PINS +: BANK_PINS] = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= (out_q | (set_v & ~lock_q)) & ~(clr_v & ~lock_q);
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_in;

  AST_OUT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (((out_q ^ $past(out_q)) & $past(lock_q)) == '0)); // R3

  // read path
  logic [NUM_BANKS-1:0][31:0] out_b, syn_b, ist_b, msk_b, lock_b;
  assign out_b  = out_q;
  assign syn_b  = sync_v;
  assign ist_b  = ist_v;
  assign msk_b  = msk_v;
  assign lock_b = lock_q;

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (in_bank) begin
      unique case (grp)
        GRP_OUT, GRP_SET, GRP_CLR: rd_mux = out_b[bsel];
        GRP_IN:                    rd_mux = syn_b[bsel];
        GRP_IST:                   rd_mux = ist_b[bsel];
        GRP_MSK, GRP_MCL:          rd_mux = msk_b[bsel];
        default:                   rd_mux = '0;
      endcase
    end else if (in_ctrl) begin
      rd_mux = cfg_rdata;
    end else if (in_lock) begin
      rd_mux = lock_b[bsel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_mux;
    end
  end

  AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> bus_rvalid); // R6
endmodule

// File: tb/gpio_keyed_bank_test.sv
`timescale 1ns/1ps
module gpio_keyed_bank_test;
  localparam int NB = 2;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  gpio_keyed_bank #(.NUM_BANKS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  // driver: queue expected read data, then issue the read
  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic chk(input logic [NP-1:0] got, input logic [NP-1:0] e, input string tag);
    n_chk++;
    if (got !== e) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, e);
    end
  endtask

  // monitor: compare each returned read with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R6: unexpected read data %h expected none", bus_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk({63'd0, irq}, '0, "R1 irq");
    chk(pin_oe, '0, "R1 pin_oe");
    rd(12'h500, 32'hFFFF_FFFF, "R1 lock");
    rd(12'h0A0, 32'hFFFF_FFFF, "R1 mask");
    rd(12'h000, 32'h0, "R1 out");
    rd(12'h114, 32'h1, "R1 cfg pin5");
    rd(12'h080, 32'h0, "R1 status");

    // R3 locked pins ignore set
    wr(12'h040, 32'h0000_FFFF);
    rd(12'h000, 32'h0, "R3 set while locked");

    // R2 key arming
    wr(12'h500, 32'h0);
    rd(12'h500, 32'hFFFF_FFFF, "R2 lock without key");
    wr(12'h520, 32'h00A5_A501);
    wr(12'h0C4, 32'h0);
    wr(12'h500, 32'h0);
    rd(12'h500, 32'hFFFF_FFFF, "R2 disarmed by other write");
    wr(12'h520, 32'h00A5_A500);
    wr(12'h500, 32'h0);
    rd(12'h500, 32'hFFFF_FFFF, "R2 wrong key");
    wr(12'h520, 32'h00A5_A501);
    wr(12'h500, 32'hFFFF_0000);
    rd(12'h500, 32'hFFFF_0000, "R2 armed lock write");
    wr(12'h500, 32'h0);
    rd(12'h500, 32'hFFFF_0000, "R2 one shot");

    // R4 configuration word
    wr(12'h10C, 32'h0000_F15E);
    rd(12'h10C, 32'h0000_0158, "R4 cfg pin3 readback");
    @(negedge clk);
    chk(pin_oe, 64'h8, "R4 pin_oe");
    wr(12'h150, 32'h0);
    rd(12'h150, 32'h1, "R3 cfg locked pin20");

    // R5 set / clear
    wr(12'h040, 32'hFFFF_FFFF);
    rd(12'h000, 32'h0000_FFFF, "R5 set");
    wr(12'h060, 32'hFFFF_0F0F);
    rd(12'h000, 32'h0000_F0F0, "R5 clear");
    rd(12'h040, 32'h0000_F0F0, "R5 read via set port");
    rd(12'h060, 32'h0000_F0F0, "R5 read via clear port");
    @(negedge clk);
    chk(pin_out, 64'h0000_F0F0, "R5 pin_out");

    // bank 1: unlock and configure
    wr(12'h520, 32'h00A5_A501);
    wr(12'h504, 32'h0);
    rd(12'h504, 32'h0, "R2 bank1 unlock");
    wr(12'h180, 32'h09);   // pin32 input rising
    wr(12'h184, 32'h11);   // pin33 input falling
    wr(12'h188, 32'h19);   // pin34 input both
    wr(12'h18C, 32'h01);   // pin35 input none
    wr(12'h190, 32'h08);   // pin36 output rising
    wr(12'h0C4, 32'h1F);
    rd(12'h0A4, 32'hFFFF_FFE0, "R9 unmask");
    rd(12'h0C4, 32'hFFFF_FFE0, "R9 mask via clear port");

    // R7 rising
    @(negedge clk);
    pin_in[36:32] = 5'b11111;
    repeat (4) @(negedge clk);
    chk({63'd0, irq}, 64'd1, "R9 irq raised");
    rd(12'h084, 32'h05, "R7 rising status");
    rd(12'h024, 32'h1F, "R6 input status");
    wr(12'h084, 32'h05);
    rd(12'h084, 32'h0, "R8 w1c all");
    @(negedge clk);
    chk({63'd0, irq}, '0, "R8 irq cleared");

    // R7 falling
    pin_in[36:32] = 5'b00000;
    repeat (4) @(negedge clk);
    rd(12'h084, 32'h06, "R7 falling status");

    // R9 masking
    wr(12'h0A4, 32'h06);
    @(negedge clk);
    chk({63'd0, irq}, '0, "R9 masked");
    rd(12'h0A4, 32'hFFFF_FFE6, "R9 mask read");
    wr(12'h0C4, 32'h02);
    @(negedge clk);
    chk({63'd0, irq}, 64'd1, "R9 unmasked");
    wr(12'h084, 32'h02);
    rd(12'h084, 32'h04, "R8 partial w1c");
    @(negedge clk);
    chk({63'd0, irq}, '0, "R9 only masked bit left");

    // R10 out-of-range
    wr(12'h044, 32'h0A);
    wr(12'h048, 32'hFF);
    rd(12'h004, 32'h0A, "R10 bank1 unaffected");
    rd(12'h008, 32'h0, "R10 bank2 read");
    rd(12'h0E0, 32'h0, "R10 unmapped group");
    rd(12'h200, 32'h0, "R10 cfg beyond last pin");
    rd(12'h520, 32'h0, "R10 key read");

    repeat (4) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R6: got %0d pending reads expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule